// File: doc/BRIEF.md
# Per-Pin Alternate Function Decoder

This block works out, for every pin of a bank, which of four functions currently drives that pin: the default function or one of the alternates A, B and C. It watches two live register bytes. The first is a bank-wide function-select byte, in which each pin owns one bit. The second is an alternate-function byte shared by the whole bank. Each pin's wiring into those bytes is fixed at elaboration through parameters. For each pin these give a select-bit index and up to two alternate-bit indices, each either 0 to REG_W-1 or the all-ones "unused" marker, plus two 2-bit codes that name alternate A and alternate B.

Pins come in two kinds. A pin with no alternate bits is a plain two-way pin, where select bit 1 means alternate A. A pin that uses the alternate byte reads its select bit the other way round. For that kind of pin, select bit 1 means default, and with select bit 0 the alternate bits form a 2-bit code that picks A, B or C. A pin whose indices are malformed is reported on a per-pin error flag and is held at the default function. The results are registered, so a pad multiplexer downstream sees a clean one-hot select that changes only on clock edges.

Top module: `afd_decoder`

## Requirements
- R1: Each pin drives a 4-bit one-hot field func_o[4*i+3:4*i] with exactly one bit set at every clock. Bit 0 is default, bit 1 is alternate A, bit 2 is alternate B and bit 3 is alternate C.
- R2: A pin whose select-bit index is the unused marker (all ones) always decodes as default, whatever the register bytes hold.
- R3: A valid pin with a used select bit and no alternate bits decodes as default when its select bit is 0 and as alternate A when it is 1.
- R4: A valid pin that uses its first alternate bit decodes as default whenever its select bit is 1, whatever the alternate byte holds.
- R5: For such a pin with select bit 0, the 2-bit code is {second alternate bit, first alternate bit}. The upper bit is taken as 0 when the second index is unused.
- R6: The code is compared with the pin's A code first and then with its B code. A match with A gives alternate A even when the B code is equal to it. If neither matches, the pin decodes as alternate C.
- R7: A pin is invalid when any of its three indices is neither below REG_W nor the unused marker, or when its second alternate index is used while its first is unused. An invalid pin sets cfg_err_o[i] and outputs default. The flag keeps its value for as long as reset stays released.
- R8: Both outputs are registered. A change on the register inputs shows up after the next rising clock edge and not before. An active-low asynchronous reset forces every field to default and clears every error flag at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_reg_i | input | REG_W | Bank function-select byte, one bit per pin |
| alt_reg_i | input | REG_W | Shared alternate-function byte |
| func_o | output | 4*NUM_PINS | Registered one-hot function per pin |
| cfg_err_o | output | NUM_PINS | Registered per-pin configuration-error flag |

## Verification
Every decoded field and every error flag is due one rising edge after the register bytes change, and an asserted reset acts at once without waiting for an edge. The bench drives new bytes on a falling edge and samples one nanosecond after the next rising edge, so each check looks at the result of exactly one input pair. Latency is checked by looking at the output between the input change and the edge, where it must still show the earlier result. Reset is checked by sampling just after rst_n falls, in the middle of a clock period.

// File: rtl/afd_pkg.sv
package afd_pkg;

   // Width of the one-hot function field per pin.
   localparam int FN_W = 4;

   // Function identifiers; the value is also the one-hot bit position.
   typedef enum logic [1:0] {
      FN_DEF  = 2'd0,
      FN_ALTA = 2'd1,
      FN_ALTB = 2'd2,
      FN_ALTC = 2'd3
   } fn_e;

   function automatic logic [FN_W-1:0] fn_to_onehot(input fn_e f);
      logic [FN_W-1:0] v;
      v = '0;
      v[f] = 1'b1;
      return v;
   endfunction

   localparam logic [FN_W-1:0] FN_DEF_OH = 4'b0001;

endpackage

// File: rtl/afd_cfg_check.sv
// Decides at elaboration whether one pin's index set is usable.
module afd_cfg_check #(
   parameter int               REG_W    = 8,
   parameter int               IDX_W    = 4,
   parameter logic [IDX_W-1:0] SEL_IDX  = '1,
   parameter logic [IDX_W-1:0] ALT1_IDX = '1,
   parameter logic [IDX_W-1:0] ALT2_IDX = '1
) (
   output logic bad_o
);
   localparam logic [IDX_W-1:0] NONE = {IDX_W{1'b1}};

   localparam bit SEL_OK  = (int'(SEL_IDX)  < REG_W) || (SEL_IDX  == NONE);
   localparam bit ALT1_OK = (int'(ALT1_IDX) < REG_W) || (ALT1_IDX == NONE);
   localparam bit ALT2_OK = (int'(ALT2_IDX) < REG_W) || (ALT2_IDX == NONE);
   localparam bit PAIR_OK = !((ALT2_IDX != NONE) && (ALT1_IDX == NONE));
   localparam bit BAD     = !(SEL_OK && ALT1_OK && ALT2_OK && PAIR_OK);

   assign bad_o = BAD;
endmodule

// File: rtl/afd_pin_decode.sv
// Combinational function decode for one pin.
module afd_pin_decode
   import afd_pkg::*;
#(
   parameter int               IDX_W     = 4,
   parameter logic [IDX_W-1:0] SEL_IDX   = '1,
   parameter logic [IDX_W-1:0] ALT1_IDX  = '1,
   parameter logic [IDX_W-1:0] ALT2_IDX  = '1,
   parameter logic [1:0]       ALTA_CODE = 2'd0,
   parameter logic [1:0]       ALTB_CODE = 2'd1
) (
   input  logic            bad_i,
   input  logic            sel_bit_i,
   input  logic            alt1_bit_i,
   input  logic            alt2_bit_i,
   output logic [FN_W-1:0] func_o
);
   localparam logic [IDX_W-1:0] NONE = {IDX_W{1'b1}};
   localparam bit SEL_USED  = (SEL_IDX  != NONE);
   localparam bit ALT1_USED = (ALT1_IDX != NONE);
   localparam bit ALT2_USED = (ALT2_IDX != NONE);

   logic [1:0] code;
   fn_e        fn;

   // The upper code bit reads as zero when no second bit is wired.
   assign code = {alt2_bit_i & ALT2_USED, alt1_bit_i};

   always_comb begin
      if (bad_i || !SEL_USED) begin
         fn = FN_DEF;
      end else if (!ALT1_USED) begin
         fn = sel_bit_i ? FN_ALTA : FN_DEF;
      end else if (sel_bit_i) begin
         // Inverted sense for pins that also use the alternate byte.
         fn = FN_DEF;
      end else if (code == ALTA_CODE) begin
         fn = FN_ALTA;
      end else if (code == ALTB_CODE) begin
         fn = FN_ALTB;
      end else begin
         fn = FN_ALTC;
      end
   end

   assign func_o = fn_to_onehot(fn);
endmodule

// File: rtl/afd_out_reg.sv
// Output register with asynchronous active-low reset to a parameter value.
module afd_out_reg #(
   parameter int           W       = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= RST_VAL;
      end else begin
         q_o <= d_i;
      end
   end
endmodule

// File: rtl/afd_decoder.sv
// Bank-level alternate function decoder: one decode slice per pin.
module afd_decoder
   import afd_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int IDX_W    = 4,
   parameter int NUM_PINS = 7,
   parameter logic [NUM_PINS*IDX_W-1:0] SEL_IDX =
      {4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'hF, 4'd0},
   parameter logic [NUM_PINS*IDX_W-1:0] ALT1_IDX =
      {4'd7, 4'd9, 4'hF, 4'd0, 4'd3, 4'hF, 4'hF},
   parameter logic [NUM_PINS*IDX_W-1:0] ALT2_IDX =
      {4'hF, 4'hF, 4'd5, 4'd1, 4'hF, 4'hF, 4'hF},
   parameter logic [NUM_PINS*2-1:0] ALTA_CODE =
      {2'd0, 2'd0, 2'd0, 2'd2, 2'd1, 2'd0, 2'd0},
   parameter logic [NUM_PINS*2-1:0] ALTB_CODE =
      {2'd1, 2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [REG_W-1:0]         sel_reg_i,
   input  logic [REG_W-1:0]         alt_reg_i,
   output logic [NUM_PINS*FN_W-1:0] func_o,
   output logic [NUM_PINS-1:0]      cfg_err_o
);
   localparam int BIT_W = $clog2(REG_W);
   localparam logic [NUM_PINS*FN_W-1:0] FUNC_RST = {NUM_PINS{FN_DEF_OH}};

   // Elaboration-time parameter checks.
   if (NUM_PINS < 1) begin : g_chk_pins
      $error("afd_decoder: NUM_PINS must be at least 1");
   end
   if (REG_W < 2 || (1 << BIT_W) != REG_W) begin : g_chk_regw
      $error("afd_decoder: REG_W must be a power of two of at least 2");
   end
   if (IDX_W != BIT_W + 1) begin : g_chk_idxw
      $error("afd_decoder: IDX_W must be clog2(REG_W)+1");
   end

   logic [NUM_PINS*FN_W-1:0] func_d;
   logic [NUM_PINS-1:0]      err_d;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam logic [IDX_W-1:0] S  = SEL_IDX [i*IDX_W +: IDX_W];
      localparam logic [IDX_W-1:0] A1 = ALT1_IDX[i*IDX_W +: IDX_W];
      localparam logic [IDX_W-1:0] A2 = ALT2_IDX[i*IDX_W +: IDX_W];

      logic bad;
      logic sel_bit;
      logic alt1_bit;
      logic alt2_bit;

      afd_cfg_check #(
         .REG_W   (REG_W),
         .IDX_W   (IDX_W),
         .SEL_IDX (S),
         .ALT1_IDX(A1),
         .ALT2_IDX(A2)
      ) u_cfg (
         .bad_o(bad)
      );

      // Low index bits address the byte; out-of-range indices are
      // masked downstream by the error flag.
      assign sel_bit  = sel_reg_i[S [BIT_W-1:0]];
      assign alt1_bit = alt_reg_i[A1[BIT_W-1:0]];
      assign alt2_bit = alt_reg_i[A2[BIT_W-1:0]];

      afd_pin_decode #(
         .IDX_W    (IDX_W),
         .SEL_IDX  (S),
         .ALT1_IDX (A1),
         .ALT2_IDX (A2),
         .ALTA_CODE(ALTA_CODE[i*2 +: 2]),
         .ALTB_CODE(ALTB_CODE[i*2 +: 2])
      ) u_dec (
         .bad_i     (bad),
         .sel_bit_i (sel_bit),
         .alt1_bit_i(alt1_bit),
         .alt2_bit_i(alt2_bit),
         .func_o    (func_d[i*FN_W +: FN_W])
      );

      assign err_d[i] = bad;
   end

   afd_out_reg #(
      .W      (NUM_PINS*FN_W),
      .RST_VAL(FUNC_RST)
   ) u_func_q (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (func_d),
      .q_o  (func_o)
   );

   afd_out_reg #(
      .W      (NUM_PINS),
      .RST_VAL('0)
   ) u_err_q (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (err_d),
      .q_o  (cfg_err_o)
   );
endmodule

// File: rtl/afd_decoder_chk.sv
// Property checker bound into afd_decoder.
module afd_decoder_chk #(
   parameter int REG_W    = 8,
   parameter int IDX_W    = 4,
   parameter int NUM_PINS = 7,
   parameter logic [NUM_PINS*IDX_W-1:0] SEL_IDX  = '1,
   parameter logic [NUM_PINS*IDX_W-1:0] ALT1_IDX = '1,
   parameter logic [NUM_PINS*IDX_W-1:0] ALT2_IDX = '1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [REG_W-1:0]       sel_reg_i,
   input logic [REG_W-1:0]       alt_reg_i,
   input logic [NUM_PINS*4-1:0]  func_o,
   input logic [NUM_PINS-1:0]    cfg_err_o
);
   localparam logic [IDX_W-1:0] NONE = {IDX_W{1'b1}};

   AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(sel_reg_i) && $stable(alt_reg_i)) |=> $stable(func_o)); // R8

   AST_ERR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)) |-> $stable(cfg_err_o)); // R7

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam logic [IDX_W-1:0] S  = SEL_IDX [i*IDX_W +: IDX_W];
      localparam logic [IDX_W-1:0] A1 = ALT1_IDX[i*IDX_W +: IDX_W];
      localparam logic [IDX_W-1:0] A2 = ALT2_IDX[i*IDX_W +: IDX_W];
      localparam bit OK = ((int'(S)  < REG_W) || (S  == NONE)) &&
                          ((int'(A1) < REG_W) || (A1 == NONE)) &&
                          ((int'(A2) < REG_W) || (A2 == NONE)) &&
                          !((A2 != NONE) && (A1 == NONE));
      localparam int SB = int'(S) % REG_W;

      AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(func_o[i*4 +: 4]) == 1); // R1

      AST_BAD_IS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_err_o[i] |-> (func_o[i*4 +: 4] == 4'b0001)); // R7

      if (S == NONE) begin : g_nosel
         AST_NOSEL_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
            func_o[i*4 +: 4] == 4'b0001); // R2
      end else if (OK && A1 == NONE) begin : g_plain
         AST_PLAIN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |->
            (func_o[i*4 +: 4] == ($past(sel_reg_i[SB]) ? 4'b0010 : 4'b0001))); // R3
      end else if (OK) begin : g_alt
         AST_ALT_SEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(sel_reg_i[SB])) |->
            (func_o[i*4 +: 4] == 4'b0001)); // R4
      end
   end
endmodule

bind afd_decoder afd_decoder_chk #(
   .REG_W   (REG_W),
   .IDX_W   (IDX_W),
   .NUM_PINS(NUM_PINS),
   .SEL_IDX (SEL_IDX),
   .ALT1_IDX(ALT1_IDX),
   .ALT2_IDX(ALT2_IDX)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_reg_i(sel_reg_i),
   .alt_reg_i(alt_reg_i),
   .func_o   (func_o),
   .cfg_err_o(cfg_err_o)
);

// File: tb/afd_decoder_test.sv
`timescale 1ns/1ps
module afd_decoder_test;
   // Default configuration, pin: sel idx / alt1 / alt2 / A code / B code
   // p0: 0/-/-     p1: -/-/-     p2: 2/3/- A=1 B=1   p3: 3/0/1 A=2 B=1
   // p4: 4/-/5 bad p5: 5/9/- bad p6: 6/7/- A=0 B=1
   // Field nibble: 1=default 2=alt A 4=alt B 8=alt C.
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sel = 8'h00;
   logic [7:0]  alt = 8'h00;
   logic [27:0] func;
   logic [6:0]  err;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   afd_decoder uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_reg_i(sel),
      .alt_reg_i(alt),
      .func_o   (func),
      .cfg_err_o(err)
   );

   // {sel, alt, expected func}
   localparam logic [43:0] VEC [9] = '{
      {8'h00, 8'h00, 28'h2118811},
      {8'hFF, 8'h00, 28'h1111112},
      {8'h00, 8'h8A, 28'h4112211},
      {8'h00, 8'h01, 28'h2114811},
      {8'h00, 8'h0B, 28'h2118211},
      {8'h08, 8'h02, 28'h2111811},
      {8'h05, 8'hFF, 28'h4118112},
      {8'h30, 8'h22, 28'h2112811},
      {8'h40, 8'h80, 28'h1118811}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [7:0] s, input logic [7:0] a);
      @(negedge clk);
      sel = s;
      alt = a;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // Reset state, with busy inputs (R8)
      sel = 8'hFF;
      alt = 8'hFF;
      repeat (3) @(posedge clk);
      #1;
      chk("R8 reset func", {4'h0, func}, 32'h01111111);
      chk("R8 reset err", {25'h0, err}, 32'h0);
      chk("R1 reset one-hot", {4'h0, func}, 32'h01111111);

      @(negedge clk);
      rst_n = 1'b1;
      sel = 8'h00;
      alt = 8'h00;
      @(posedge clk);
      #1;
      chk("R7 error flags", {25'h0, err}, 32'h30);

      // Table walk
      for (int k = 0; k < 9; k++) begin
         apply(VEC[k][43:36], VEC[k][35:28]);
         chk($sformatf("R1 R3 R5 R6 vector %0d", k), {4'h0, func}, {4'h0, VEC[k][27:0]});
      end

      // R2: unused select index ignores both bytes
      apply(8'hFF, 8'hFF);
      chk("R2 pin1 all ones", {28'h0, func[7:4]}, 32'h1);
      apply(8'h00, 8'h00);
      chk("R2 pin1 all zeros", {28'h0, func[7:4]}, 32'h1);

      // R4: inverted select on pin6 overrides alternate byte
      apply(8'h40, 8'h80);
      chk("R4 pin6 sel high", {28'h0, func[27:24]}, 32'h1);
      apply(8'h00, 8'h80);
      chk("R4 pin6 sel low alt B", {28'h0, func[27:24]}, 32'h4);

      // R5/R6: pin2 code 1 with A=B=1 gives A; code 0 gives C
      apply(8'h00, 8'h08);
      chk("R5 R6 pin2 priority", {28'h0, func[11:8]}, 32'h2);
      apply(8'h00, 8'hF7);
      chk("R5 pin2 upper bit ignored", {28'h0, func[11:8]}, 32'h8);

      // R7: invalid pins stay default with all bits set
      apply(8'hFF, 8'hFF);
      chk("R7 bad pins default", {24'h0, func[23:16]}, 32'h11);
      chk("R7 flags held", {25'h0, err}, 32'h30);

      // R8: latency of one edge
      apply(8'h00, 8'h00);
      @(negedge clk);
      sel = 8'h01;
      #1;
      chk("R8 before edge", {4'h0, func}, 32'h02118811);
      @(posedge clk);
      #1;
      chk("R8 after edge", {4'h0, func}, 32'h02118812);

      // R8: asynchronous reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R8 async reset func", {4'h0, func}, 32'h01111111);
      chk("R8 async reset err", {25'h0, err}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R8 recovery", {4'h0, func}, 32'h02118812);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule